// File: doc/BRIEF.md
# Nonvolatile Memory Access Control Register

This block is the control and status byte that a CPU uses to drive a self-timed nonvolatile memory. Software writes the whole byte over a register bus and can read it back at any time. The byte picks the target space (data EEPROM, program flash or configuration), arms writes with an enable bit and holds a row-erase mode bit. Two self-clearing start bits launch either a single-cycle read or a timed write or erase cycle.

A built-in cycle timer owns the memory-side handshake. It raises a request with an operation code and a target code, keeps both steady for the whole cycle, and pulses a done strobe in the last busy cycle. Completion clears the write start bit, clears the error flag and, after an erase, clears the erase mode bit. A synchronous reset that arrives during a timed cycle stops the cycle and sets a sticky error flag. The space selection is left as it was, so software can see which operation failed.

Top module: `nvm_ctl_reg`

## Requirements
- R1: The register reads as bit 7 program-space select, bit 6 configuration select, bit 5 always 0 whatever was written, bit 4 erase mode, bit 3 error flag, bit 2 write enable, bit 1 write start, bit 0 read start. A register write loads bits 7, 6, 4, 3 and 2 from the written byte.
- R2: Write start is set only by a register write with bit 1 at 1. Writing 0 to bit 1 while a cycle runs leaves it at 1. It returns to 0 on the edge that ends the timed cycle.
- R3: An accepted read start reads as 1 for exactly one cycle. In that cycle mem_req is 1, mem_op is 2'b01 (read) and mem_busy stays 0.
- R4: A read start is refused, and bit 0 stays 0 with no request, when the same write sets bit 7 to 1, when a timed cycle is busy, or when a write start is accepted in the same access.
- R5: A write start is accepted only if write enable was already 1 before the access and no cycle is busy. Otherwise bit 1 stays 0 and no request is raised.
- R6: If the written bit 4 is 1 when a write start is accepted, the cycle is an erase with mem_op 2'b11 lasting ERASE_CYCLES cycles. Its completion clears bit 4. A plain write uses mem_op 2'b10.
- R7: A timed cycle holds mem_busy high for exactly WRITE_CYCLES or ERASE_CYCLES clock cycles from the accepting edge. mem_done is high only in the last of them.
- R8: mem_space is 2'b10 when configuration select is 1, otherwise 2'b01 when program-space select is 1, otherwise 2'b00. It is captured at the start and, like mem_op, does not change during a cycle even if the register is rewritten.
- R9: A reset while mem_busy is 1 ends the cycle (mem_busy, mem_req and bit 1 go to 0) and sets the error flag to 1. Bits 7 and 6 keep their values.
- R10: Reset clears write enable, erase mode and both start bits. It does not change bits 7 and 6, and it leaves the error flag alone when no cycle is running.
- R11: A timed cycle that completes clears the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (covers master and watchdog resets) |
| reg_wr_en | input | 1 | Register write strobe, one byte per asserted cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| mem_req | output | 1 | Memory request, high for a read cycle or a timed cycle |
| mem_op | output | 2 | Operation: 01 read, 10 write, 11 row erase |
| mem_space | output | 2 | Target: 00 data EEPROM, 01 program flash, 10 configuration |
| mem_busy | output | 1 | Timed cycle in progress |
| mem_done | output | 1 | One-cycle strobe in the last cycle of a timed cycle |

## Verification
The assertions assume that the register bus delivers at most one byte per cycle and that reset is sampled only at clock edges. They also assume the cycle-length parameters are at least 1, so every timed cycle has a last busy cycle that carries the done strobe. The stimulus changes the write strobe, data and reset only at falling edges. It leaves the retained select and error bits out of its comparisons until the first full register write has given them a defined value.

// File: rtl/nvm_ctl_pkg.sv
// Shared encodings for the nonvolatile memory access control register.
// Assumes: an 8-bit register whose bit positions are fixed by software use.
package nvm_ctl_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_ERASE = 2'b11
    } nvm_op_e;

    typedef enum logic [1:0] {
        SP_DATA = 2'b00,
        SP_PROG = 2'b01,
        SP_CONF = 2'b10
    } nvm_space_e;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned B_PROG   = 7;
    localparam int unsigned B_CONF   = 6;
    localparam int unsigned B_RSVD   = 5;
    localparam int unsigned B_ERASE  = 4;
    localparam int unsigned B_ERR    = 3;
    localparam int unsigned B_WEN    = 2;
    localparam int unsigned B_WSTART = 1;
    localparam int unsigned B_RSTART = 0;

    // Configuration select wins over program-space select.
    function automatic nvm_space_e decode_space(input logic prog, input logic conf);
        if (conf)      return SP_CONF;
        else if (prog) return SP_PROG;
        else           return SP_DATA;
    endfunction
endpackage

// File: rtl/nvm_cycle_timer.sv
// Self-timed cycle counter. A start loads a length and busy stays high for
// exactly that many cycles; done marks the last one.
// Assumes: len_i >= 1, and start_i is only raised while idle.
module nvm_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             busy_o,
    output logic             done_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load on start, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= len_i - CNT_W'(1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    // R7: the done strobe lasts one cycle and ends the busy period.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R5: the register never starts a second cycle while one runs.
    a_r5_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/nvm_req_hold.sv
// Captures operation and target at the start of a read or timed cycle and
// holds them for the memory side.
// Assumes: start_i and read_i are never high together.
module nvm_req_hold
    import nvm_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       read_i,
    input  logic       erase_i,
    input  logic       prog_i,
    input  logic       conf_i,
    input  logic       busy_i,
    input  logic       done_i,
    output nvm_op_e    op_o,
    output nvm_space_e space_o
);
    timeunit 1ns;
    timeprecision 1ps;

    nvm_op_e    op_q;
    nvm_space_e space_q;

    // Latch the request fields only when a new operation begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            space_q <= SP_DATA;
        end else if (start_i) begin
            op_q    <= erase_i ? OP_ERASE : OP_WRITE;
            space_q <= decode_space(prog_i, conf_i);
        end else if (read_i) begin
            op_q    <= OP_READ;
            space_q <= decode_space(prog_i, conf_i);
        end
    end

    assign op_o    = op_q;
    assign space_o = space_q;

    // R8: request fields are steady through a timed cycle.
    a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> ($stable(op_o) && $stable(space_o)));
    // R3: an accepted read presents the read code.
    a_r3_read_code: assert property (@(posedge clk) disable iff (!rst_n)
        read_i |=> (op_o == OP_READ));
endmodule

// File: rtl/nvm_ctl_bits.sv
// Register bits: software writes, start-bit acceptance, hardware clears and
// the abort error flag.
// Assumes: busy_i/done_i come from the cycle timer; erase_done_i is done_i
// qualified by an erase operation.
module nvm_ctl_bits
    import nvm_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic             erase_done_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             start_o,
    output logic             read_o,
    output logic             rd_pulse_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic prog_q, conf_q, free_q, err_q, wen_q, wr_q, rd_q;

    // Acceptance of the two start requests in the current access.
    assign start_o = wr_en_i && wdata_i[B_WSTART] && wen_q && !busy_i;
    assign read_o  = wr_en_i && wdata_i[B_RSTART] && !wdata_i[B_PROG]
                     && !busy_i && !start_o;

    // Space selects survive reset, so reset does not touch them.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en_i) begin
            prog_q <= wdata_i[B_PROG];
            conf_q <= wdata_i[B_CONF];
        end
    end

    // Error flag: set by a reset that aborts a cycle, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (busy_i) err_q <= 1'b1;
        end else if (done_i) begin
            err_q <= 1'b0;
        end else if (wr_en_i) begin
            err_q <= wdata_i[B_ERR];
        end
    end

    // Write enable follows software and is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       wen_q <= 1'b0;
        else if (wr_en_i) wen_q <= wdata_i[B_WEN];
    end

    // Erase mode follows software; an erase completion clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)            free_q <= 1'b0;
        else if (erase_done_i) free_q <= 1'b0;
        else if (wr_en_i)      free_q <= wdata_i[B_ERASE];
    end

    // Write start: set only on acceptance, cleared only by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_q <= 1'b0;
        else if (start_o) wr_q <= 1'b1;
        else if (done_i)  wr_q <= 1'b0;
    end

    // Read start: one cycle high after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= read_o;
    end

    // Read-back assembly; the unused position is tied low.
    always_comb begin
        rdata_o           = '0;
        rdata_o[B_PROG]   = prog_q;
        rdata_o[B_CONF]   = conf_q;
        rdata_o[B_RSVD]   = 1'b0;
        rdata_o[B_ERASE]  = free_q;
        rdata_o[B_ERR]    = err_q;
        rdata_o[B_WEN]    = wen_q;
        rdata_o[B_WSTART] = wr_q;
        rdata_o[B_RSTART] = rd_q;
    end

    assign rd_pulse_o = rd_q;

    // R2: software cannot clear write start; completion does.
    a_r2_wr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && !done_i) |=> wr_q);
    a_r2_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !wr_q);
    // R3: read start is a single-cycle pulse.
    a_r3_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> !rd_q);
    // R4: no read start while program space is selected.
    a_r4_rd_not_prog: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> !prog_q);
    // R6: an erase completion clears erase mode.
    a_r6_erase_clears_free: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done_i |=> !free_q);
    // R11: completion clears the error flag.
    a_r11_done_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !err_q);
    // R9: reset during a cycle flags the error.
    a_r9_abort_sets_err: assert property (@(posedge clk)
        (!rst_n && busy_i) |=> err_q);
    // R10: reset clears the enable, mode and start bits.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!wen_q && !free_q && !wr_q && !rd_q));
endmodule

// File: rtl/nvm_ctl_reg.sv
// Top of the nonvolatile memory access control register: register bits,
// request capture and the self-timed cycle counter.
// Assumes: WRITE_CYCLES and ERASE_CYCLES are both at least 1.
module nvm_ctl_reg
    import nvm_ctl_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 16,
    parameter int unsigned ERASE_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       mem_req,
    output logic [1:0] mem_op,
    output logic [1:0] mem_space,
    output logic       mem_busy,
    output logic       mem_done
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WR_LEN = CNT_W'(WRITE_CYCLES);
    localparam logic [CNT_W-1:0] ER_LEN = CNT_W'(ERASE_CYCLES);

    logic             start, read_go, rd_pulse, busy, done, erase_done;
    logic [CNT_W-1:0] cyc_len;
    nvm_op_e          op_q;
    nvm_space_e       space_q;

    // Cycle length picked from the erase mode being written with the start.
    assign cyc_len    = reg_wdata[B_ERASE] ? ER_LEN : WR_LEN;
    assign erase_done = done && (op_q == OP_ERASE);

    nvm_ctl_bits i_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (reg_wr_en),
        .wdata_i      (reg_wdata),
        .busy_i       (busy),
        .done_i       (done),
        .erase_done_i (erase_done),
        .rdata_o      (reg_rdata),
        .start_o      (start),
        .read_o       (read_go),
        .rd_pulse_o   (rd_pulse)
    );

    nvm_req_hold i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .read_i  (read_go),
        .erase_i (reg_wdata[B_ERASE]),
        .prog_i  (reg_wdata[B_PROG]),
        .conf_i  (reg_wdata[B_CONF]),
        .busy_i  (busy),
        .done_i  (done),
        .op_o    (op_q),
        .space_o (space_q)
    );

    nvm_cycle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .len_i   (cyc_len),
        .busy_o  (busy),
        .done_o  (done)
    );

    assign mem_req   = busy | rd_pulse;
    assign mem_op    = op_q;
    assign mem_space = space_q;
    assign mem_busy  = busy;
    assign mem_done  = done;

    // R9: reset removes any pending request on the next edge.
    a_r9_reset_drops_req: assert property (@(posedge clk)
        !rst_n |=> !mem_req);
    // R3: a read request never overlaps a timed cycle.
    a_r3_read_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |-> !busy);
endmodule

// File: tb/test_nvm_ctl_reg.sv
// Bench: behavioural per-cycle model compared at every falling edge, plus
// named checks at the points the requirements call out.
module test_nvm_ctl_reg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WRC = 5;
    localparam int ERC = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mem_req, mem_busy, mem_done;
    logic [1:0] mem_op, mem_space;

    int    n_chk = 0;
    int    n_err = 0;
    string cur = "R10";
    bit    cmp_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    nvm_ctl_reg #(.WRITE_CYCLES(WRC), .ERASE_CYCLES(ERC)) i_nvm_ctl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_op    (mem_op),
        .mem_space (mem_space),
        .mem_busy  (mem_busy),
        .mem_done  (mem_done)
    );

    // Reference model state
    logic m_pg = 0, m_cf = 0, m_free = 0, m_err = 0, m_wren = 0, m_wr = 0, m_rd = 0;
    int   m_rem = 0;
    logic [1:0] m_op = 0, m_sp = 0;
    logic [7:0] known = 8'h37;

    always @(posedge clk) begin
        int   old_rem;
        logic st, rdg;
        old_rem = m_rem;
        if (!rst_n) begin
            if (old_rem > 0) m_err = 1;
            m_rem = 0; m_wr = 0; m_rd = 0; m_wren = 0; m_free = 0;
        end else begin
            st = 0; rdg = 0;
            if (reg_wr_en) begin
                st  = reg_wdata[1] && m_wren && (old_rem == 0);
                rdg = reg_wdata[0] && !reg_wdata[7] && (old_rem == 0) && !st;
                m_pg = reg_wdata[7]; m_cf = reg_wdata[6]; m_free = reg_wdata[4];
                m_err = reg_wdata[3]; m_wren = reg_wdata[2];
                known = 8'hFF;
            end
            if (old_rem == 1) begin
                m_rem = 0; m_wr = 0; m_err = 0;
                if (m_op == 2'b11) m_free = 0;
            end else if (old_rem > 1) begin
                m_rem = old_rem - 1;
            end
            if (st) begin
                m_op = m_free ? 2'b11 : 2'b10;
                m_sp = m_cf ? 2'b10 : (m_pg ? 2'b01 : 2'b00);
                m_rem = m_free ? ERC : WRC;
                m_wr = 1;
            end
            if (rdg) begin
                m_op = 2'b01;
                m_sp = m_cf ? 2'b10 : (m_pg ? 2'b01 : 2'b00);
            end
            m_rd = rdg;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [7:0] ev;
        if (cmp_on) begin
            ev = {m_pg, m_cf, 1'b0, m_free, m_err, m_wren, m_wr, m_rd};
            chk({cur, " rdata"}, reg_rdata & known, ev & known);
            chk({cur, " busy"}, {7'd0, mem_busy}, {7'd0, m_rem > 0});
            chk({cur, " done"}, {7'd0, mem_done}, {7'd0, m_rem == 1});
            chk({cur, " req"}, {7'd0, mem_req}, {7'd0, (m_rem > 0) || m_rd});
            if (mem_req) begin
                chk({cur, " op"}, {6'd0, mem_op}, {6'd0, m_op});
                chk({cur, " space"}, {6'd0, mem_space}, {6'd0, m_sp});
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Waits for the busy period to end; returns busy and done positions.
    task automatic wait_idle(input int seen, output int nb, output int dn);
        nb = seen; dn = 0;
        forever begin
            @(negedge clk);
            if (!mem_busy) break;
            nb++;
            if (mem_done) dn = nb;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int nb, dn;
        repeat (3) @(negedge clk);
        chk("R10 reset bits", reg_rdata & 8'h37, 8'h00);
        chk("R10 reset req", {7'd0, mem_req}, 8'h00);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        cur = "R1";
        wr(8'h00);
        chk("R1 cleared", reg_rdata, 8'h00);
        wr(8'hFF);
        chk("R1 R4 R5 all ones", reg_rdata, 8'hDC);
        chk("R5 no request", {7'd0, mem_req}, 8'h00);

        cur = "R5";
        wr(8'h00);
        wr(8'h06);
        chk("R5 enable in same access", reg_rdata, 8'h04);
        chk("R5 not busy", {7'd0, mem_busy}, 8'h00);

        cur = "R7";
        wr(8'h06);
        chk("R2 start set", reg_rdata, 8'h06);
        chk("R8 write op", {6'd0, mem_op}, 8'h02);
        chk("R8 data space", {6'd0, mem_space}, 8'h00);
        cur = "R2";
        wr(8'h84);
        chk("R2 zero write ignored", reg_rdata, 8'h86);
        chk("R8 space held", {6'd0, mem_space}, 8'h00);
        wr(8'h07);
        chk("R4 R5 busy refusal", reg_rdata, 8'h06);
        cur = "R7";
        wait_idle(3, nb, dn);
        chk("R7 write length", nb[7:0], WRC[7:0]);
        chk("R7 done position", dn[7:0], WRC[7:0]);
        chk("R2 cleared at end", reg_rdata, 8'h04);

        cur = "R3";
        wr(8'h05);
        chk("R3 read pulse", reg_rdata, 8'h05);
        chk("R3 read op", {mem_req, mem_busy, 4'd0, mem_op}, 8'h81);
        @(negedge clk);
        chk("R3 pulse ends", {mem_req, reg_rdata[6:0]}, 8'h04);

        cur = "R6";
        wr(8'h56);
        chk("R6 erase op", {6'd0, mem_op}, 8'h03);
        chk("R8 config space", {6'd0, mem_space}, 8'h02);
        wait_idle(1, nb, dn);
        chk("R6 erase length", nb[7:0], ERC[7:0]);
        chk("R6 erase mode cleared", reg_rdata, 8'h44);

        cur = "R11";
        wr(8'h0C);
        wr(8'h0E);
        chk("R11 error held while busy", reg_rdata, 8'h0E);
        wait_idle(1, nb, dn);
        chk("R11 error cleared", reg_rdata, 8'h04);

        cur = "R4";
        wr(8'h81);
        chk("R4 program space refusal", reg_rdata, 8'h80);
        chk("R4 no request", {7'd0, mem_req}, 8'h00);

        cur = "R9";
        wr(8'h84);
        wr(8'h86);
        chk("R8 program space", {6'd0, mem_space}, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 R10 abort state", reg_rdata, 8'h88);
        chk("R9 cycle stopped", {mem_req, mem_busy, 6'd0}, 8'h00);
        @(negedge clk);
        cur = "R10";
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 idle reset keeps error", reg_rdata, 8'h88);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule